// File: doc/BRIEF.md
# Programmable Matrix Color Space Converter

This block converts a stream of three-component pixels, eight bits per component, into clamped eight-bit RGB. It does this by applying a software-loaded 3x4 affine matrix. Each output channel takes a weighted sum of the three input components and adds a constant. The matrix entries are signed fixed-point words. The sum is floored back to an integer and limited to the 0..255 range. The arithmetic runs in a three-stage pipeline that accepts one pixel per clock. A valid flag travels along with each pixel.

Software programs the block through a small register port with a single-cycle write and a combinational read. The port holds a control word and twelve coefficient words. While conversion is disabled, pixels pass through untouched, with the same latency and valid timing. The block can convert YUV to RGB or YVU to RGB, because swapping the two chroma inputs only means exchanging two coefficient columns.

Top module: `mtx_csc`

## Requirements
- R1: After reset, every register reads zero, conversion is disabled, and `pix_valid_o` and `pix_o` are zero.
- R2: The control word sits at byte offset 0x00. Bit 0 enables conversion. Only bit 0 is stored, so a read returns that bit in position 0 with zeros above it.
- R3: Coefficient word i, for i from 0 to 11, sits at byte offset 0x10 + 4*i. Each one stores a full 32-bit value and reads it back unchanged. Word 4*r + j, with j = 0..2, weights input component j for output channel r. Word 4*r + 3 is the additive constant for output channel r.
- R4: A read of any other address, including addresses whose two low bits are not zero, returns zero. A write to such an address changes no register.
- R5: With conversion enabled, output channel r equals clamp((w0*c0 + w1*c1 + w2*c2 + k) >>> 10). The values c0, c1 and c2 are the unsigned input components: component 0 in `pix_i[7:0]`, component 1 in `[15:8]`, component 2 in `[23:16]`. The weights w and the constant k are two's complement words in which 0x400 stands for 1.0. Output channel r is placed in `pix_o[8r+7:8r]`.
- R6: The shift by 10 floors toward negative infinity. A product of exactly 1.5 gives 1. Adding 0x200 to the constant turns the result into round-to-nearest.
- R7: A negative channel result gives 0, and a result above 255 gives 255.
- R8: A pixel accepted with `pix_valid_i` high at a rising edge appears on `pix_o`, with `pix_valid_o` high, after exactly three rising edges. Back-to-back pixels come out back to back.
- R9: With conversion disabled, `pix_o` equals the accepted `pix_i`, with the same three-edge latency.
- R10: A register write at one edge applies to pixels accepted from the next edge on. The pixel accepted at the same edge as the write still uses the old settings, and so do pixels already in the pipeline.
- R11: Loading coefficient columns 1 and 2 swapped, and feeding components 1 and 2 swapped, gives the same output as the unswapped case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_i | input | 24 | Input pixel, component 0 in the low byte |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_o | output | 24 | Output pixel, channel 0 in the low byte |

## Verification
Register reads are combinational, so the bench sets the address at a falling edge and checks `reg_rdata` 1 ns later. A write is checked once the rising edge that stores it has passed. Each pixel is driven at a falling edge and its result is checked at the third falling edge after that. At the first and second falling edges in between, the bench confirms that `pix_valid_o` is still low. For the write-ordering case, a control write and a pixel are driven on the same falling edge and a second pixel follows at the next one. The two results are then expected on two consecutive falling edges: the first passes through unconverted and the second is converted.

// File: rtl/csc_pkg.sv
package csc_pkg;
    // Byte offsets of the programmable words
    localparam int CTRL_OFS = 'h00;
    localparam int COEF_OFS = 'h10;

    // Register address decode result
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_COEF = 2'd2
    } sel_e;
endpackage

// File: rtl/csc_regs.sv
module csc_regs
    import csc_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int NCOEF  = 12
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    output logic [DATA_W-1:0]             rdata,
    output logic                          en_o,
    output logic [NCOEF-1:0][DATA_W-1:0]  coef_o
);
    localparam int IDX_W  = $clog2(NCOEF);
    localparam int WORD_W = ADDR_W - 2;

    typedef struct packed {
        logic                         en;
        logic [NCOEF-1:0][DATA_W-1:0] coef;
    } regs_t;

    regs_t             st_d, st_q;
    sel_e              sel;
    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] rel;

    // Address decode: aligned words only
    always_comb begin
        rel = addr - ADDR_W'(COEF_OFS);
        sel = SEL_NONE;
        idx = '0;
        if (addr[1:0] == 2'b00) begin
            if (addr == ADDR_W'(CTRL_OFS)) begin
                sel = SEL_CTRL;
            end else if ((addr >= ADDR_W'(COEF_OFS)) &&
                         (rel[ADDR_W-1:2] < WORD_W'(NCOEF))) begin
                sel = SEL_COEF;
                idx = IDX_W'(rel[ADDR_W-1:2]);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (sel)
                SEL_CTRL: st_d.en        = wdata[0];
                SEL_COEF: st_d.coef[idx] = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (sel)
            SEL_CTRL: rdata = DATA_W'(st_q.en);
            SEL_COEF: rdata = st_q.coef[idx];
            default:  rdata = '0;
        endcase
    end

    assign en_o   = st_q.en;
    assign coef_o = st_q.coef;

    // Writes outside the map leave all storage unchanged
    assert_unmapped_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_NONE) |=> (st_q == $past(st_q)));

    // A coefficient write lands in the addressed word
    assert_coef_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_COEF) |=> (coef_o[$past(idx)] == $past(wdata)));

    // A control write updates the enable bit
    assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_CTRL) |=> (en_o == $past(wdata[0])));
endmodule

// File: rtl/csc_row.sv
module csc_row #(
    parameter int PIX_W  = 8,
    parameter int NIN    = 3,
    parameter int COEF_W = 32,
    parameter int FRAC_W = 10
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NIN-1:0][PIX_W-1:0]    pix,
    input  logic [NIN:0][COEF_W-1:0]     coef,   // [NIN] is the constant
    output logic [PIX_W-1:0]             res
);
    localparam int PROD_W = COEF_W + PIX_W + 1;
    localparam int SUM_W  = PROD_W + $clog2(NIN + 1);
    localparam logic signed [SUM_W-1:0] MAXV = SUM_W'((1 << PIX_W) - 1);

    typedef struct packed {
        logic [NIN-1:0][PROD_W-1:0] prod;   // stage 1: products
        logic [COEF_W-1:0]          kon;    // stage 1: constant snapshot
        logic [SUM_W-1:0]           sum;    // stage 2: accumulated sum
        logic [PIX_W-1:0]           res;    // stage 3: clamped result
    } row_t;

    row_t                    st_d, st_q;
    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] shf;

    always_comb begin
        st_d = st_q;
        // Stage 1: signed weight times zero-extended component
        for (int j = 0; j < NIN; j++) begin
            st_d.prod[j] = PROD_W'($signed(coef[j])) *
                           PROD_W'($signed({1'b0, pix[j]}));
        end
        st_d.kon = coef[NIN];
        // Stage 2: sum of products plus constant
        acc = SUM_W'($signed(st_q.kon));
        for (int j = 0; j < NIN; j++) begin
            acc = acc + SUM_W'($signed(st_q.prod[j]));
        end
        st_d.sum = acc;
        // Stage 3: floor shift and clamp
        shf = $signed(st_q.sum) >>> FRAC_W;
        if (shf < 0)          st_d.res = '0;
        else if (shf > MAXV)  st_d.res = '1;
        else                  st_d.res = shf[PIX_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign res = st_q.res;

    // Negative sums clamp to zero
    assert_clamp_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(st_q.sum) < 0) |=> (res == '0));

    // Sums beyond full scale clamp to the maximum code
    assert_clamp_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (($signed(st_q.sum) >>> FRAC_W) > MAXV) |=> (res == '1));
endmodule

// File: rtl/mtx_csc.sv
module mtx_csc #(
    parameter int PIX_W  = 8,
    parameter int NCH    = 3,
    parameter int COEF_W = 32,
    parameter int FRAC_W = 10,
    parameter int ADDR_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_we,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [COEF_W-1:0]     reg_wdata,
    output logic [COEF_W-1:0]     reg_rdata,
    input  logic                  pix_valid_i,
    input  logic [NCH*PIX_W-1:0]  pix_i,
    output logic                  pix_valid_o,
    output logic [NCH*PIX_W-1:0]  pix_o
);
    localparam int NCOEF  = NCH * (NCH + 1);
    localparam int PIXV_W = NCH * PIX_W;
    localparam int LAT    = 3;            // stages inside csc_row

    typedef struct packed {
        logic [LAT-1:0]             vld;
        logic [LAT-1:0]             en;
        logic [LAT-1:0][PIXV_W-1:0] pix;
        logic [1:0]                 warm;  // edges since reset, saturating
    } pipe_t;

    pipe_t                        st_d, st_q;
    logic                         ctrl_en;
    logic [NCOEF-1:0][COEF_W-1:0] coef_q;
    logic [NCH-1:0][PIX_W-1:0]    conv;

    csc_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (COEF_W),
        .NCOEF  (NCOEF)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .rdata  (reg_rdata),
        .en_o   (ctrl_en),
        .coef_o (coef_q)
    );

    for (genvar r = 0; r < NCH; r++) begin : g_row
        csc_row #(
            .PIX_W  (PIX_W),
            .NIN    (NCH),
            .COEF_W (COEF_W),
            .FRAC_W (FRAC_W)
        ) u_row (
            .clk   (clk),
            .rst_n (rst_n),
            .pix   (pix_i),
            .coef  (coef_q[r*(NCH+1) +: (NCH+1)]),
            .res   (conv[r])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = {st_q.vld[LAT-2:0], pix_valid_i};
        st_d.en  = {st_q.en[LAT-2:0], ctrl_en};
        st_d.pix = {st_q.pix[LAT-2:0], pix_i};
        if (st_q.warm != 2'd3) st_d.warm = st_q.warm + 2'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_valid_o = st_q.vld[LAT-1];
    assign pix_o       = st_q.en[LAT-1] ? PIXV_W'(conv) : st_q.pix[LAT-1];

    // Valid emerges exactly three edges after acceptance
    assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm == 2'd3) |-> (pix_valid_o == $past(pix_valid_i, 3)));

    // Disabled at entry: output equals the accepted input
    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.warm == 2'd3 && pix_valid_o && !$past(ctrl_en, 3))
            |-> (pix_o == $past(pix_i, 3)));
endmodule

// File: tb/tb_mtx_csc.sv
module tb_mtx_csc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        pix_valid_i = 1'b0;
    logic [23:0] pix_i = '0;
    logic        pix_valid_o;
    logic [23:0] pix_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [31:0] shadow [12];
    logic        shadow_en = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    mtx_csc dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pix_valid_i(pix_valid_i), .pix_i(pix_i),
        .pix_valid_o(pix_valid_o), .pix_o(pix_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Expected output from the stated formula
    function automatic logic [23:0] model(input logic [23:0] p);
        logic [23:0] o;
        longint s;
        if (!shadow_en) return p;
        for (int r = 0; r < 3; r++) begin
            s = longint'($signed(shadow[4*r+3]));
            for (int j = 0; j < 3; j++)
                s += longint'($signed(shadow[4*r+j])) * longint'(p[8*j +: 8]);
            s = s >>> 10;
            if (s < 0) o[8*r +: 8] = 8'd0;
            else if (s > 255) o[8*r +: 8] = 8'd255;
            else o[8*r +: 8] = s[7:0];
        end
        return o;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        if (a == 8'h00) shadow_en = d[0];
        else if (a[1:0] == 2'b00 && a >= 8'h10 && a < 8'h40) shadow[(a - 8'h10) >> 2] = d;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    // One pixel through an idle pipeline, checked at the due edge
    task automatic px_chk(input string req, input logic [23:0] p, input logic [23:0] exp);
        @(negedge clk);
        pix_valid_i = 1'b1; pix_i = p;
        @(negedge clk);
        pix_valid_i = 1'b0;
        chk("R8 early valid", {31'b0, pix_valid_o}, 32'd0);
        @(negedge clk);
        chk("R8 early valid", {31'b0, pix_valid_o}, 32'd0);
        @(negedge clk);
        chk("R8 valid due", {31'b0, pix_valid_o}, 32'd1);
        chk(req, {8'b0, pix_o}, {8'b0, exp});
    endtask

    task automatic load(input logic [31:0] t [12]);
        for (int i = 0; i < 12; i++) wr(8'h10 + 8'(4*i), t[i]);
    endtask

    logic [31:0] yuv [12] = '{32'h4A8, 32'h0, 32'h662, 32'hFFFC865A,
                              32'h4A8, 32'hFFFFFE6F, 32'hFFFFFCBF, 32'h00021FF4,
                              32'h4A8, 32'h813, 32'h0, 32'hFFFBAE4A};
    logic [31:0] yvu [12] = '{32'h4A8, 32'h662, 32'h0, 32'hFFFC865A,
                              32'h4A8, 32'hFFFFFCBF, 32'hFFFFFE6F, 32'h00021FF4,
                              32'h4A8, 32'h0, 32'h813, 32'hFFFBAE4A};

    task automatic t_reset;
        #1;
        chk("R1 valid", {31'b0, pix_valid_o}, 32'd0);
        chk("R1 pix", {8'b0, pix_o}, 32'd0);
        rd_chk("R1 ctrl", 8'h00, 32'd0);
        rd_chk("R1 coef0", 8'h10, 32'd0);
        rd_chk("R1 coef11", 8'h3C, 32'd0);
    endtask

    task automatic t_regs;
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R2 ctrl bit0 only", 8'h00, 32'd1);
        wr(8'h00, 32'h0);
        rd_chk("R2 ctrl clear", 8'h00, 32'd0);
        for (int i = 0; i < 12; i++) wr(8'h10 + 8'(4*i), 32'hA500_0000 + 32'(i * 'h111));
        for (int i = 0; i < 12; i++) rd_chk("R3 coef readback", 8'h10 + 8'(4*i), 32'hA500_0000 + 32'(i * 'h111));
    endtask

    task automatic t_unmapped;
        wr(8'h04, 32'h1);
        wr(8'h12, 32'hDEAD_BEEF);
        wr(8'h40, 32'h1234_5678);
        wr(8'hFC, 32'h1);
        rd_chk("R4 read 0x04", 8'h04, 32'd0);
        rd_chk("R4 read 0x12", 8'h12, 32'd0);
        rd_chk("R4 read 0x40", 8'h40, 32'd0);
        rd_chk("R4 ctrl untouched", 8'h00, 32'd0);
        rd_chk("R4 coef0 untouched", 8'h10, 32'hA500_0000);
        rd_chk("R4 coef11 untouched", 8'h3C, 32'hA500_0000 + 32'(11 * 'h111));
    endtask

    task automatic t_bypass;
        px_chk("R9 bypass", 24'h12_34_56, 24'h12_34_56);
        px_chk("R9 bypass", 24'hFF_00_80, 24'hFF_00_80);
    endtask

    task automatic t_convert;
        load(yuv);
        wr(8'h00, 32'h1);
        px_chk("R5 black", {8'd128, 8'd128, 8'd16}, 24'h00_00_00);
        px_chk("R5 white", {8'd128, 8'd128, 8'd235}, 24'hFF_FF_FF);
        px_chk("R5 red", {8'd240, 8'd90, 8'd81}, model({8'd240, 8'd90, 8'd81}));
        px_chk("R5 mixed", {8'd40, 8'd200, 8'd120}, model({8'd40, 8'd200, 8'd120}));
        px_chk("R7 clamp high", {8'd128, 8'd128, 8'd255}, 24'hFF_FF_FF);
        px_chk("R7 clamp low", {8'd128, 8'd128, 8'd0}, 24'h00_00_00);
    endtask

    task automatic t_floor;
        logic [31:0] t [12];
        for (int i = 0; i < 12; i++) t[i] = 32'h0;
        t[0] = 32'h200;                       // 0.5 weight on channel 0
        load(t);
        px_chk("R6 floor 1.5", {16'h0, 8'd3}, 24'h00_00_01);
        wr(8'h1C, 32'h200);                   // bias half an LSB
        px_chk("R6 rounded 1.5", {16'h0, 8'd3}, 24'h00_00_02);
    endtask

    task automatic t_swap;
        logic [23:0] ref_out;
        load(yuv);
        ref_out = model({8'd240, 8'd90, 8'd81});
        load(yvu);
        px_chk("R11 swapped columns", {8'd90, 8'd240, 8'd81}, ref_out);
    endtask

    task automatic t_write_order;
        logic [23:0] a, b, exp_b;
        a = {8'd240, 8'd90, 8'd81};
        b = {8'd128, 8'd128, 8'd235};
        load(yuv);
        wr(8'h00, 32'h0);
        shadow_en = 1'b1;
        exp_b = model(b);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 8'h00; reg_wdata = 32'h1;
        pix_valid_i = 1'b1; pix_i = a;
        @(negedge clk);
        reg_we = 1'b0; pix_i = b;
        @(negedge clk);
        pix_valid_i = 1'b0;
        @(negedge clk);
        chk("R10 same-edge pixel valid", {31'b0, pix_valid_o}, 32'd1);
        chk("R10 same-edge pixel uses old", {8'b0, pix_o}, {8'b0, a});
        @(negedge clk);
        chk("R8 back-to-back valid", {31'b0, pix_valid_o}, 32'd1);
        chk("R10 next pixel uses new", {8'b0, pix_o}, {8'b0, exp_b});
        @(negedge clk);
        chk("R8 valid drops", {31'b0, pix_valid_o}, 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_unmapped();
        wr(8'h00, 32'h0);
        t_bypass();
        t_convert();
        t_floor();
        wr(8'h00, 32'h1);
        t_swap();
        t_write_order();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule